// File: doc/BRIEF.md
# Single-Cycle Eight-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock. In that clock it fetches the instruction, reads the register file, runs the ALU, accesses memory and writes the result back. It supports register add, register subtract, signed set-less-than, add-immediate, word load, word store, branch-if-equal and absolute jump. Any other opcode, or an R-type function code outside the three supported ones, retires as a no-op: the PC moves forward and no state changes.

Instruction and data storage are small internal word arrays. The arrays use combinational reads and write on the clock edge. A debug port loads and inspects both arrays. While the debug enable is high, the core freezes: the PC holds and no register or memory write from an instruction takes effect. A writeback trace on the ports reports each register write in the cycle it commits, so an outside scoreboard can follow execution.

A parameter chooses how branch-if-equal compares its two operands. It can reuse the ALU subtract and test the result for zero, or it can use a separate equality comparator.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 general registers to 0.
- R2: Every instruction that is not a jump and not a taken branch advances the PC by exactly 4. Instruction words are fetched from word index PC[N:2].
- R3: R-type (opcode 0x00) with funct 0x20 writes rs+rt to rd, and funct 0x22 writes rs-rt to rd, both modulo 2^32. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0].
- R4: addi (opcode 0x08) writes rs plus the immediate [15:0] to rt. The immediate is sign-extended by copying bit 15 into bits 31:16.
- R5: slt (R-type, funct 0x2A) writes 1 to rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R6: sw (0x2B) stores rt, and lw (0x23) loads into rt, at the data word whose index is bits [N:2] of rs + sign-extended immediate.
- R7: beq (0x04) sets the PC to (PC+4) + (sign-extended immediate << 2) when rs equals rt, and to PC+4 otherwise.
- R8: j (0x02) sets the PC to {upper 4 bits of PC+4, target [25:0], 2'b00}.
- R9: Register 0 always reads as 0. A write that targets it is discarded and does not appear on the writeback trace.
- R10: An unsupported opcode or function code changes neither registers nor data memory, and the PC advances by 4.
- R11: While dbg_en is high, the PC holds and no instruction writes. With dbg_we high, the debug port writes dbg_wdata at word dbg_addr of data storage (dbg_dmem=1) or instruction storage (dbg_dmem=0). dbg_rdata shows that word combinationally.
- R12: wb_en, wb_idx and wb_data show the register index and value being written in the same cycle the write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Freeze the core and enable the debug port |
| dbg_dmem | input | 1 | Debug target: 1 = data storage, 0 = instruction storage |
| dbg_we | input | 1 | Debug write strobe |
| dbg_addr | input | DBG_AW | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Word read from the selected storage at dbg_addr |
| pc_q | output | 32 | Current program counter |
| wb_en | output | 1 | A register write commits this cycle |
| wb_idx | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value being written |

## Verification
Each instruction commits within its own cycle, so a wrong internal value shows at the ports one clock later at the latest. A wrong decode, ALU result or sign extension produces a wrong wb_data, or a wrong or missing wb_en, in the cycle the instruction runs. A wrong next-PC choice produces a wrong pc_q on the following cycle, and the whole instruction stream behind it then diverges. A store to the wrong word is visible only when that word is loaded again or read back through the debug port. Stores that must not happen are therefore caught by pre-filling data storage with marker values and checking them after the run.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ADDI  = 6'h08;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_J     = 6'h02;

   localparam logic [5:0] FN_ADD   = 6'h20;
   localparam logic [5:0] FN_SUB   = 6'h22;
   localparam logic [5:0] FN_SLT   = 6'h2A;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_SLT = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    reg_write;
      logic    dst_rd;
      logic    use_imm;
      logic    mem_read;
      logic    mem_write;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '{reg_write: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, mem_read: 1'b0,
              mem_write: 1'b0, branch: 1'b0, jump: 1'b0, alu_op: ALU_ADD};
      unique case (opcode)
         OP_RTYPE: begin
            ctl.dst_rd = 1'b1;
            unique case (funct)
               FN_ADD:  begin ctl.reg_write = 1'b1; ctl.alu_op = ALU_ADD; end
               FN_SUB:  begin ctl.reg_write = 1'b1; ctl.alu_op = ALU_SUB; end
               FN_SLT:  begin ctl.reg_write = 1'b1; ctl.alu_op = ALU_SLT; end
               default: ctl.reg_write = 1'b0;
            endcase
         end
         OP_ADDI: begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; end
         OP_LW:   begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.mem_read = 1'b1; end
         OP_SW:   begin ctl.use_imm = 1'b1; ctl.mem_write = 1'b1; end
         OP_BEQ:  begin ctl.branch = 1'b1; ctl.alu_op = ALU_SUB; end
         OP_J:    ctl.jump = 1'b1;
         default: ctl.reg_write = 1'b0;
      endcase
   end

   // at most one kind of architectural effect per decoded instruction
   always_comb begin
      AST_CTRL_ONE_EFFECT: assert ($onehot0({ctl.reg_write, ctl.mem_write, ctl.branch, ctl.jump}))
         else $error("decoder raised more than one effect"); // R10
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y,
   output logic         zero
);
   always_comb begin
      unique case (op)
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);

   // a negative first operand against a non-negative second must compare as less
   always_comb begin
      if (op == ALU_SLT && a[W-1] && !b[W-1])
         AST_SLT_SIGNED: assert (y == W'(1)) else $error("slt compared unsigned"); // R5
   end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W     = 32,
   parameter int N     = 32,
   parameter int NREAD = 2,
   localparam int AW   = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr [NREAD],
   output logic [W-1:0]  rdata [NREAD]
);
   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) regs[i] <= '0;
      end else if (we && waddr != '0) begin
         regs[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NREAD; p++) begin : g_rd
      assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
   end
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
   parameter int W     = 32,
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [W-1:0]  rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [W-1:0]  rdata_b
);
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_depth
      $error("sc_mem: WORDS must be a power of two of at least 2");
   end

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_WORDS  = 64,
   parameter int DMEM_WORDS  = 64,
   parameter int DBG_AW      = 8,
   parameter bit BEQ_VIA_ALU = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dbg_en,
   input  logic              dbg_dmem,
   input  logic              dbg_we,
   input  logic [DBG_AW-1:0] dbg_addr,
   input  logic [31:0]       dbg_wdata,
   output logic [31:0]       dbg_rdata,
   output logic [31:0]       pc_q,
   output logic              wb_en,
   output logic [4:0]        wb_idx,
   output logic [31:0]       wb_data
);
   localparam int W     = 32;
   localparam int NREG  = 32;
   localparam int RAW   = $clog2(NREG);
   localparam int IAW   = $clog2(IMEM_WORDS);
   localparam int DAW   = $clog2(DMEM_WORDS);

   if (DBG_AW < IAW || DBG_AW < DAW) begin : g_bad_dbg
      $error("sc_core: DBG_AW too narrow for the storage arrays");
   end

   logic            run;
   logic [W-1:0]    instr, pc_next, pc4, br_tgt, jmp_tgt, sext;
   logic [W-1:0]    rs_val, rt_val, alu_b, alu_y, ld_val, res_val;
   logic            alu_zero, src_equal;
   logic [RAW-1:0]  dst;
   logic [RAW-1:0]  rf_ra [2];
   logic [W-1:0]    rf_rd [2];
   logic [W-1:0]    imem_dbg, dmem_dbg;
   logic            dmem_we, imem_we;
   logic [DAW-1:0]  dmem_waddr;
   logic [W-1:0]    dmem_wdata;
   ctrl_t           ctl;

   assign run = !rst && !dbg_en;

   // fetch
   sc_mem #(.W(W), .WORDS(IMEM_WORDS)) u_imem (
      .clk(clk), .we(imem_we), .waddr(dbg_addr[IAW-1:0]), .wdata(dbg_wdata),
      .raddr_a(pc_q[IAW+1:2]), .rdata_a(instr),
      .raddr_b(dbg_addr[IAW-1:0]), .rdata_b(imem_dbg));

   assign imem_we = !rst && dbg_en && dbg_we && !dbg_dmem;

   // decode and register read
   sc_ctrl u_ctrl (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

   assign sext     = {{16{instr[15]}}, instr[15:0]};
   assign rf_ra[0] = instr[25:21];
   assign rf_ra[1] = instr[20:16];
   assign rs_val   = rf_rd[0];
   assign rt_val   = rf_rd[1];
   assign dst      = ctl.dst_rd ? instr[15:11] : instr[20:16];

   sc_regfile #(.W(W), .N(NREG), .NREAD(2)) u_rf (
      .clk(clk), .rst(rst), .we(wb_en), .waddr(dst), .wdata(res_val),
      .raddr(rf_ra), .rdata(rf_rd));

   // execute
   assign alu_b = ctl.use_imm ? sext : rt_val;

   sc_alu #(.W(W)) u_alu (.a(rs_val), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero));

   if (BEQ_VIA_ALU) begin : g_cmp_alu
      assign src_equal = alu_zero;
   end else begin : g_cmp_direct
      assign src_equal = (rs_val == rt_val);
   end

   // memory
   assign dmem_we    = dbg_en ? (!rst && dbg_we && dbg_dmem) : (run && ctl.mem_write);
   assign dmem_waddr = dbg_en ? dbg_addr[DAW-1:0] : alu_y[DAW+1:2];
   assign dmem_wdata = dbg_en ? dbg_wdata : rt_val;

   sc_mem #(.W(W), .WORDS(DMEM_WORDS)) u_dmem (
      .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
      .raddr_a(alu_y[DAW+1:2]), .rdata_a(ld_val),
      .raddr_b(dbg_addr[DAW-1:0]), .rdata_b(dmem_dbg));

   assign dbg_rdata = dbg_dmem ? dmem_dbg : imem_dbg;

   // writeback
   assign res_val = ctl.mem_read ? ld_val : alu_y;
   assign wb_en   = run && ctl.reg_write && (dst != '0);
   assign wb_idx  = dst;
   assign wb_data = res_val;

   // next PC
   assign pc4     = pc_q + 32'd4;
   assign br_tgt  = pc4 + {sext[W-3:0], 2'b00};
   assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

   always_comb begin
      pc_next = pc4;
      if (ctl.jump)                      pc_next = jmp_tgt;
      else if (ctl.branch && src_equal)  pc_next = br_tgt;
   end

   always_ff @(posedge clk) begin
      if (rst)      pc_q <= '0;
      else if (run) pc_q <= pc_next;
   end

   logic unused_bits;
   assign unused_bits = ^{instr, alu_y, pc_q, dbg_addr, alu_zero};

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      (run && !ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4))
      else $error("PC did not step by 4"); // R2

   AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
      (run && ctl.branch && (rs_val != rt_val)) |=> (pc_q == $past(pc_q) + 32'd4))
      else $error("unequal beq redirected"); // R7

   AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
      (run && ctl.jump) |=> (pc_q[31:28] == $past(pc4[31:28]) && pc_q[1:0] == 2'b00))
      else $error("jump left its region"); // R8

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
      dbg_en |=> $stable(pc_q))
      else $error("PC moved while halted"); // R11
endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;
   localparam int DBG_AW = 8;

   logic              clk = 1'b0;
   logic              rst;
   logic              dbg_en, dbg_dmem, dbg_we;
   logic [DBG_AW-1:0] dbg_addr;
   logic [31:0]       dbg_wdata, dbg_rdata, pc_q, wb_data;
   logic              wb_en;
   logic [4:0]        wb_idx;

   always #2 clk = ~clk;

   sc_core #(.DBG_AW(DBG_AW)) u_sc_core (
      .clk(clk), .rst(rst), .dbg_en(dbg_en), .dbg_dmem(dbg_dmem), .dbg_we(dbg_we),
      .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
      .pc_q(pc_q), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data));

   int checks = 0;
   int errors = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   // scoreboard queues
   logic [36:0] wb_exp [$];
   string       wb_tag [$];
   logic [31:0] pc_exp [$];
   string       pc_tag [$];

   task automatic push_wb(input int idx, input logic [31:0] val, input string tag);
      wb_exp.push_back({5'(idx), val});
      wb_tag.push_back(tag);
   endtask
   task automatic push_pc(input logic [31:0] val, input string tag);
      pc_exp.push_back(val);
      pc_tag.push_back(tag);
   endtask

   // monitor
   always @(negedge clk) begin
      if (!rst && !dbg_en) begin
         if (pc_exp.size() > 0) check(pc_tag.pop_front(), pc_q, pc_exp.pop_front());
         if (wb_en) begin
            if (wb_exp.size() == 0) begin
               checks++;
               errors++;
               $display("FAIL R9 unexpected write: actual r%0d=%h expected none", wb_idx, wb_data);
            end else begin
               automatic logic [36:0] e = wb_exp.pop_front();
               automatic string t = wb_tag.pop_front();
               check({t, " index"}, {27'd0, wb_idx}, {27'd0, e[36:32]});
               check({t, " value"}, wb_data, e[31:0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   logic [31:0] prog [19];

   initial begin
      prog[0]  = enc_i(6'h08, 0, 1, 16'd5);          // addi r1,r0,5
      prog[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);       // addi r2,r0,-3
      prog[2]  = enc_r(1, 2, 3, 6'h20);              // add r3,r1,r2
      prog[3]  = enc_r(2, 1, 4, 6'h22);              // sub r4,r2,r1
      prog[4]  = enc_r(2, 1, 5, 6'h2A);              // slt r5,r2,r1
      prog[5]  = enc_r(1, 2, 6, 6'h2A);              // slt r6,r1,r2
      prog[6]  = enc_i(6'h08, 0, 0, 16'd7);          // addi r0,r0,7
      prog[7]  = enc_r(11, 1, 7, 6'h20);             // add r7,r11,r1
      prog[8]  = enc_i(6'h2B, 1, 4, 16'd7);          // sw r4,7(r1)
      prog[9]  = enc_i(6'h23, 0, 8, 16'd12);         // lw r8,12(r0)
      prog[10] = {6'h3F, 26'h0123456};               // unsupported
      prog[11] = enc_i(6'h04, 1, 2, 16'd5);          // beq r1,r2 not taken
      prog[12] = enc_i(6'h04, 1, 7, 16'd2);          // beq r1,r7 taken -> 60
      prog[13] = enc_i(6'h08, 0, 9, 16'd1);          // skipped
      prog[14] = enc_i(6'h08, 0, 9, 16'd2);          // skipped
      prog[15] = {6'h02, 26'd18};                    // j -> 72
      prog[16] = enc_i(6'h08, 0, 9, 16'd3);          // skipped
      prog[17] = enc_i(6'h08, 0, 9, 16'd4);          // skipped
      prog[18] = enc_i(6'h04, 0, 0, 16'hFFFF);       // beq r0,r0,-1 self loop

      rst = 1'b1; dbg_en = 1'b1; dbg_dmem = 1'b0; dbg_we = 1'b0;
      dbg_addr = '0; dbg_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pc", pc_q, 32'd0);
      @(posedge clk); #1 rst = 1'b0;

      // load program and data markers through the debug port
      for (int i = 0; i < 19; i++) begin
         dbg_dmem = 1'b0; dbg_addr = DBG_AW'(i); dbg_wdata = prog[i]; dbg_we = 1'b1;
         @(posedge clk); #1;
      end
      for (int i = 0; i < 8; i++) begin
         dbg_dmem = 1'b1; dbg_addr = DBG_AW'(i); dbg_wdata = 32'hA5A5_0000 + i; dbg_we = 1'b1;
         @(posedge clk); #1;
      end
      dbg_we = 1'b0; dbg_dmem = 1'b0; dbg_addr = 8'd9;
      #1 check("R11 instruction readback", dbg_rdata, prog[9]);
      check("R11 halted pc", pc_q, 32'd0);

      // expected stream
      push_wb(1, 32'd5,        "R4 addi positive");
      push_wb(2, 32'hFFFFFFFD, "R4 addi negative");
      push_wb(3, 32'd2,        "R3 add");
      push_wb(4, 32'hFFFFFFF8, "R3 sub");
      push_wb(5, 32'd1,        "R5 slt less");
      push_wb(6, 32'd0,        "R5 slt not less");
      push_wb(7, 32'd5,        "R1 cleared register read");
      push_wb(8, 32'hFFFFFFF8, "R6 load after store");
      for (int i = 0; i <= 10; i++) push_pc(32'(4 * i), "R2 sequential pc");
      push_pc(32'd44, "R10 no-op advance");
      push_pc(32'd48, "R7 beq not taken");
      push_pc(32'd60, "R7 beq taken");
      push_pc(32'd72, "R8 jump target");
      for (int i = 0; i < 5; i++) push_pc(32'd72, "R7 backward beq");

      @(posedge clk); #1 dbg_en = 1'b0;
      repeat (20) @(posedge clk);
      #1 dbg_en = 1'b1;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 pc held while halted", pc_q, 32'd72);
      check("R11 no write while halted", {31'd0, wb_en}, 32'd0);
      check("R12 writeback stream drained", 32'(wb_exp.size()), 32'd0);

      dbg_dmem = 1'b1;
      for (int i = 0; i < 8; i++) begin
         dbg_addr = DBG_AW'(i);
         #1;
         if (i == 3) check("R6 stored word", dbg_rdata, 32'hFFFFFFF8);
         else        check("R10 data marker untouched", dbg_rdata, 32'hA5A5_0000 + i);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule